// File: doc/BRIEF.md
# Page Write Buffer and Word Address Counter

This block sits between a two-wire serial protocol engine and a 512-byte non-volatile array, which is modelled here as a synchronous RAM. The protocol engine gives it four kinds of request. It can load a word address. It can hand over a received data byte. It can ask for the next byte to send. It can signal that the bus stop condition has ended a write sequence. The block keeps the word address counter. It gathers written bytes in a 16-entry page buffer with one valid flag per entry. On a stop, it programs only the flagged bytes into the array. A write-cycle timer then keeps the block busy for a fixed number of clocks, which stands in for the programming time. While busy, the block refuses every request, so a bus master polling for an acknowledge gets no answer until the cycle is over. A write-protect input turns the device into a read-only store.

The commit sequencer is a three-state machine. IDLE is the rest state and the only one that accepts requests. IDLE goes to PROGRAM on the transition START, which is a commit while write protect is low and at least one buffer entry is flagged. PROGRAM walks the 16 buffer slots, one per clock, and writes each flagged slot into the current page. PROGRAM goes to SETTLE on the transition SWEPT, after the last slot. SETTLE goes back to IDLE on the transition EXPIRED, once the timer has counted `TWR_CYCLES` busy clocks in total since START. Any other commit taken in IDLE is a no-op for the sequencer: this covers a commit under write protect and a commit with no flagged entry.

Top module: `eeprom_page_ctl`

## Requirements
- R1: After reset `busy` is 0 and the address counter is 0. Reset does not alter the array contents.
- R2: Each accepted read returns the byte at the counter in `rd_data`, valid from the clock edge after the `rd_en` cycle. The full 9-bit counter then advances by one, so address 511 wraps to 0.
- R3: Each accepted write stores `wr_data` in the buffer slot selected by counter bits [3:0]. Only those four bits advance. Bits [8:4] (the page) stay fixed, so writes wrap from offset 15 to offset 0 of the same page.
- R4: The counter keeps the last accessed address plus one across transactions and across commits. A read with no new address load continues from that value.
- R5: A commit changes only the array bytes whose buffer slots received data since the last address load. All other bytes of the page are unchanged.
- R6: If more than 16 bytes are written in one sequence, later bytes overwrite the slots they wrap onto. The array receives the last value written to each slot.
- R7: A commit that starts a write cycle raises `busy` on the clock edge that samples the commit. `busy` then stays high for exactly `TWR_CYCLES` cycles. The new bytes are readable once `busy` is low.
- R8: A commit with no buffered byte, such as the address-only write before a random read, leaves `busy` low, keeps the loaded address, and changes no array byte.
- R9: A commit while `wp` is 1 is dropped. `busy` stays low and the array is unchanged. Reads work normally.
- R10: While `busy` is 1, address loads, writes, reads and commits are ignored. The counter, the array and `rd_data` keep their values, and a second commit does not extend the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Load the word address and clear all buffer valid flags |
| addr_in | input | 9 | Word address to load |
| wr_en | input | 1 | Put one byte into the page buffer |
| wr_data | input | 8 | Byte to buffer |
| rd_en | input | 1 | Read one byte from the array and advance the counter |
| rd_data | output | 8 | Read byte, registered |
| commit | input | 1 | Stop condition ending a write sequence |
| wp | input | 1 | Write protect; 1 blocks programming |
| busy | output | 1 | Write cycle in progress; all requests are refused |

## Verification
The hardest case to reach is a request that arrives while a write cycle is running. Such a request must leave no trace, and that can only be shown after the cycle ends and through the same ports. The stimulus starts a real commit. During the busy window it issues an address load, a data byte, a read and a second commit. It then checks three things. The busy window still has its exact length. A plain read continues from the counter value left by the earlier write. The address named by the refused load still holds its old byte. The rest of the bench first programs the whole array, then sweeps reads across the array and its wrap point, and runs partial, wrapping and overflowing page writes over every start offset.

// File: rtl/eeprom_page_pkg.sv
package eeprom_page_pkg;

    typedef enum logic [1:0] {
        WC_IDLE,
        WC_PROGRAM,
        WC_SETTLE
    } wc_state_t;

endpackage

// File: rtl/eeprom_addr_ctr.sv
module eeprom_addr_ctr #(
    parameter int AW = 9,
    parameter int OW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step_page,
    input  logic          step_full,
    output logic [AW-1:0] cnt
);
    logic [AW-1:0] cnt_q;
    logic [OW-1:0] low_next;

    assign low_next = cnt_q[OW-1:0] + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (step_page) begin
            cnt_q <= {cnt_q[AW-1:OW], low_next};
        end else if (step_full) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/eeprom_page_slots.sv
module eeprom_page_slots #(
    parameter int OW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          put,
    input  logic [OW-1:0] put_slot,
    input  logic [DW-1:0] put_data,
    input  logic [OW-1:0] get_slot,
    output logic [DW-1:0] get_data,
    output logic          get_valid,
    output logic          any_valid
);
    localparam int SLOTS = 1 << OW;

    logic [SLOTS-1:0] vld_q;
    logic [DW-1:0]    dat_q [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[i] <= 1'b0;
            end else if (clr) begin
                vld_q[i] <= 1'b0;
            end else if (put && put_slot == OW'(i)) begin
                vld_q[i] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (put && put_slot == OW'(i)) begin
                dat_q[i] <= put_data;
            end
        end
    end

    assign get_data  = dat_q[get_slot];
    assign get_valid = vld_q[get_slot];
    assign any_valid = |vld_q;
endmodule

// File: rtl/eeprom_wc_seq.sv
module eeprom_wc_seq
    import eeprom_page_pkg::*;
#(
    parameter int OW  = 4,
    parameter int TWR = 625000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          slot_valid,
    output logic          busy,
    output logic          prog_we,
    output logic [OW-1:0] prog_slot,
    output logic          swept
);
    localparam int SLOTS = 1 << OW;
    localparam int TW    = $clog2(TWR + 1);
    localparam logic [TW-1:0] LAST_SLOT = TW'(SLOTS - 1);
    localparam logic [TW-1:0] LAST_TICK = TW'(TWR - 1);

    wc_state_t     state_q, state_d;
    logic [TW-1:0] tmr_q, tmr_d;

    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q;
        unique case (state_q)
            WC_IDLE: begin
                if (start) begin
                    state_d = WC_PROGRAM;
                    tmr_d   = '0;
                end
            end
            WC_PROGRAM: begin
                tmr_d = tmr_q + 1'b1;
                if (tmr_q == LAST_SLOT) begin
                    state_d = WC_SETTLE;
                end
            end
            WC_SETTLE: begin
                tmr_d = tmr_q + 1'b1;
                if (tmr_q == LAST_TICK) begin
                    state_d = WC_IDLE;
                end
            end
            default: begin
                state_d = WC_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WC_IDLE;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
        end
    end

    always_comb begin
        busy      = (state_q != WC_IDLE);
        prog_slot = tmr_q[OW-1:0];
        prog_we   = (state_q == WC_PROGRAM) && slot_valid;
        swept     = (state_q == WC_PROGRAM) && (tmr_q == LAST_SLOT);
    end
endmodule

// File: rtl/eeprom_cell_ram.sv
module eeprom_cell_ram #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        if (re) begin
            rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/eeprom_page_ctl.sv
module eeprom_page_ctl #(
    parameter int AW         = 9,
    parameter int OW         = 4,
    parameter int DW         = 8,
    parameter int TWR_CYCLES = 625000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_load,
    input  logic [AW-1:0] addr_in,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic          commit,
    input  logic          wp,
    output logic          busy
);
    localparam int PW = AW - OW;

    logic          idle, ld_ok, wr_ok, rd_ok, commit_ok, start;
    logic [AW-1:0] cnt_q;
    logic [PW-1:0] page_q;
    logic          any_valid, slot_valid, prog_we, swept;
    logic [OW-1:0] prog_slot;
    logic [DW-1:0] slot_data;
    logic [AW-1:0] ram_addr;

    assign idle      = !busy;
    assign ld_ok     = idle && addr_load;
    assign wr_ok     = idle && wr_en && !addr_load;
    assign rd_ok     = idle && rd_en && !addr_load && !wr_en;
    assign commit_ok = idle && commit;
    assign start     = commit_ok && !wp && any_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (wr_ok) begin
            page_q <= cnt_q[AW-1:OW];
        end
    end

    eeprom_addr_ctr #(.AW(AW), .OW(OW)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld_ok),
        .load_val  (addr_in),
        .step_page (wr_ok),
        .step_full (rd_ok),
        .cnt       (cnt_q)
    );

    eeprom_page_slots #(.OW(OW), .DW(DW)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ld_ok || (commit_ok && wp) || swept),
        .put       (wr_ok),
        .put_slot  (cnt_q[OW-1:0]),
        .put_data  (wr_data),
        .get_slot  (prog_slot),
        .get_data  (slot_data),
        .get_valid (slot_valid),
        .any_valid (any_valid)
    );

    eeprom_wc_seq #(.OW(OW), .TWR(TWR_CYCLES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .slot_valid (slot_valid),
        .busy       (busy),
        .prog_we    (prog_we),
        .prog_slot  (prog_slot),
        .swept      (swept)
    );

    assign ram_addr = busy ? {page_q, prog_slot} : cnt_q;

    eeprom_cell_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .addr  (ram_addr),
        .we    (prog_we),
        .wdata (slot_data),
        .re    (rd_ok),
        .rdata (rd_data)
    );
endmodule

// File: rtl/eeprom_page_ctl_chk.sv
module eeprom_page_ctl_chk #(
    parameter int AW  = 9,
    parameter int OW  = 4,
    parameter int DW  = 8,
    parameter int TWR = 625000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          addr_load,
    input logic          wr_en,
    input logic          rd_en,
    input logic [DW-1:0] rd_data,
    input logic          commit,
    input logic          wp,
    input logic          busy,
    input logic [AW-1:0] cnt,
    input logic          any_valid
);
    localparam int BW = $clog2(TWR + 2);

    logic [BW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    assert_busy_from_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(commit));

    assert_busy_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_q < BW'(TWR));

    assert_busy_exact_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q == BW'(TWR));

    assert_wp_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && wp && !busy) |=> !busy);

    assert_empty_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !any_valid && !busy) |=> !busy);

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en) |=> $stable(rd_data));

    assert_ctr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$fell(busy)) |=> $stable(cnt));

    assert_page_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && !addr_load) |=>
            (cnt[AW-1:OW] == $past(cnt[AW-1:OW])) &&
            (cnt[OW-1:0] == $past(cnt[OW-1:0]) + 1'b1));

    assert_read_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rd_en && !addr_load && !wr_en) |=> cnt == $past(cnt) + 1'b1);
endmodule

bind eeprom_page_ctl eeprom_page_ctl_chk #(
    .AW(AW), .OW(OW), .DW(DW), .TWR(TWR_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_load (addr_load),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .commit    (commit),
    .wp        (wp),
    .busy      (busy),
    .cnt       (cnt_q),
    .any_valid (any_valid)
);

// File: tb/eeprom_page_ctl_test.sv
module eeprom_page_ctl_test;
    localparam int TWR = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_load = 1'b0;
    logic [8:0] addr_in = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       commit = 1'b0;
    logic       wp = 1'b0;
    logic       busy;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [7:0] exp_mem [512];
    int         m_cnt = 0;
    int         pend_a [64];
    logic [7:0] pend_d [64];
    int         n_pend = 0;

    always #4 clk = ~clk;

    eeprom_page_ctl #(.TWR_CYCLES(TWR)) uut (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .commit(commit), .wp(wp), .busy(busy)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [7:0] pat(input int a, input int salt);
        return 8'((a * 37 + salt * 101 + (a >> 3)) ^ 8'h5A);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ld(input int a);
        addr_load = 1'b1;
        addr_in   = 9'(a);
        @(negedge clk);
        addr_load = 1'b0;
        m_cnt  = a;
        n_pend = 0;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        pend_a[n_pend] = m_cnt;
        pend_d[n_pend] = d;
        n_pend++;
        m_cnt = (m_cnt & 9'h1F0) | ((m_cnt + 1) & 15);
    endtask

    task automatic rd(input string req);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(rd_data == exp_mem[m_cnt], req, rd_data, exp_mem[m_cnt]);
        m_cnt = (m_cnt + 1) % 512;
    endtask

    task automatic do_commit(output int cycles);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        cycles = 0;
        while (busy && cycles < 1000) begin
            cycles++;
            @(negedge clk);
        end
        if (!wp) begin
            for (int i = 0; i < n_pend; i++) exp_mem[pend_a[i]] = pend_d[i];
        end
        n_pend = 0;
    endtask

    task automatic read_page(input int pg, input string req);
        int c;
        ld(pg * 16);
        do_commit(c);
        for (int i = 0; i < 16; i++) rd(req);
    endtask

    initial begin
        int c;
        logic [7:0] held;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy in reset", busy, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);

        // Program the whole array page by page; each cycle must last TWR (R7).
        for (int p = 0; p < 32; p++) begin
            ld(p * 16);
            for (int i = 0; i < 16; i++) wr(pat(p * 16 + i, 0));
            do_commit(c);
            chk(c == TWR, "R7 busy length", c, TWR);
        end

        // Reset keeps contents, counter returns to 0 (R1).
        ld(300);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_cnt = 0;
        @(negedge clk);
        rd("R1 counter zero after reset");

        // Full read sweep through the wrap at 511 (R2).
        ld(0);
        do_commit(c);
        chk(c == 0, "R8 dummy commit no busy", c, 0);
        for (int i = 0; i < 514; i++) rd("R2 sequential read");
        ld(509);
        do_commit(c);
        for (int i = 0; i < 5; i++) rd("R2 wrap 511 to 0");

        // Partial page write over every start offset and several lengths (R5, R3, R4).
        for (int off = 0; off < 16; off++) begin
            int len;
            len = (off % 5) + 1;
            ld(9'h120 + off);
            for (int i = 0; i < len; i++) wr(pat(off * 16 + i, 3));
            do_commit(c);
            chk(c == TWR, "R7 partial busy", c, TWR);
            rd("R4 counter kept after write");
            read_page(9'h12, "R5 partial page");
        end

        // Write wrapping from offset 14 (R3).
        ld(9'h2DE);
        for (int i = 0; i < 4; i++) wr(pat(i, 7));
        do_commit(c);
        read_page(9'h2D, "R3 write wrap in page");
        ld(9'h2E0);
        do_commit(c);
        rd("R3 next page untouched");

        // Overflow: 20 bytes, last writer wins (R6).
        ld(9'h050);
        for (int i = 0; i < 20; i++) wr(pat(i, 9));
        do_commit(c);
        rd("R6 counter after overflow");
        read_page(9'h05, "R6 overflow last wins");

        // Write protect (R9).
        wp = 1'b1;
        ld(9'h300);
        wr(8'hA5);
        wr(8'h3C);
        do_commit(c);
        chk(c == 0, "R9 no busy under wp", c, 0);
        read_page(9'h30, "R9 array unchanged");
        wp = 1'b0;

        // Empty commit keeps address, no cycle (R8).
        ld(9'h1C7);
        do_commit(c);
        chk(c == 0, "R8 empty commit", c, 0);
        rd("R8 address kept");

        // Requests during busy are ignored (R10).
        ld(9'h100);
        wr(8'hC3);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        for (int i = 0; i < n_pend; i++) exp_mem[pend_a[i]] = pend_d[i];
        n_pend = 0;
        addr_load = 1'b1;
        addr_in   = 9'h1F0;
        @(negedge clk);
        addr_load = 1'b0;
        wr_en   = 1'b1;
        wr_data = 8'hEE;
        @(negedge clk);
        wr_en = 1'b0;
        held  = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(rd_data == held, "R10 rd_data held", rd_data, held);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        c = 4;
        while (busy && c < 1000) begin
            c++;
            @(negedge clk);
        end
        chk(c == TWR, "R10 busy not extended", c, TWR);
        rd("R10 counter unaffected");
        ld(9'h1F0);
        do_commit(c);
        rd("R10 refused write left array");
        read_page(9'h10, "R10 page after busy");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule